// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus master that moves bytes between system memory and a set of keyed configuration items. Software places a 16-byte descriptor in memory and then writes that descriptor's 64-bit physical address into a two-half address register. The write to the low half starts the operation. The engine fetches the descriptor and, if the descriptor asks for it, changes the current item key. It then copies item bytes out to memory, copies memory bytes into the item, or moves the item offset forward. Last of all it stores a completion word back over the descriptor's first word.

The current key and byte offset are shared with a plain selector port. While the engine is idle, a write on that port picks a key and rewinds the offset. Item contents live outside the block. The item side presents the selected key and offset. In return it supplies the item's byte length, a read-only flag and the byte at the current offset, and it accepts single-byte writes.

Top module: `cfgdma_engine`

## Requirements
- R1: The address register is zero after reset. It is cleared again when each operation ends, so a later operation started by a low-half write alone fetches from an address whose upper 32 bits are zero.
- R2: A write to the high half (`reg_half`=0) only stores bits 63:32. A write to the low half (`reg_half`=1) stores bits 31:0 and starts an operation at the full 64-bit address.
- R3: Register reads return the constant 0x51454D55 for `reg_rhalf`=0 and 0x20434647 for `reg_rhalf`=1.
- R4: The descriptor is fetched as four 32-bit word reads at the descriptor address plus 0, 4, 8 and 12. These words are the control word, the length, target-address bits 63:32 and target-address bits 31:0. In each word, bits 31:24 hold the byte at the lowest address. A memory request holds its address until it is acknowledged.
- R5: If control bit 3 (select) is set, the key becomes control bits 31:16 and the offset becomes 0 before any transfer takes place.
- R6: If control bit 1 (read) is set, `length` bytes are stored one at a time to increasing target addresses, and the offset advances by one per byte. Any byte at an offset at or past the item length is stored as 0x00. A read never sets the error bit.
- R7: If control bit 4 (write) is set and read is clear, `length` bytes are loaded from increasing target addresses and written into the item at increasing offsets.
- R8: A write whose end (offset + length) lies past the item length, or whose item is read-only, changes no item byte and leaves the offset unchanged. It completes with the error bit set.
- R9: If control bit 2 (skip) is set and read and write are both clear, the offset advances by `length` and no data byte moves.
- R10: On completion the word 0x00000001 (failure) or 0x00000000 (success) is written to the descriptor address, after the last data beat.
- R11: While `busy` is high, register writes and selector-port writes are ignored.
- R12: While idle, a selector-port write sets the key to `sel_key` and the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Address-register write strobe |
| reg_half | input | 1 | Half written: 0 = bits 63:32, 1 = bits 31:0 (starts an operation) |
| reg_wdata | input | 32 | Address-register write value |
| reg_rhalf | input | 1 | Half read: 0 = upper, 1 = lower |
| reg_rdata | output | 32 | Identification constant half |
| sel_wr | input | 1 | Selector-port write strobe |
| sel_key | input | 16 | Selector-port key |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_byte | output | 1 | 1 = single byte in bits 7:0, 0 = 32-bit word |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Request accepted at this clock edge |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| item_key | output | 16 | Current item key |
| item_off | output | 32 | Current byte offset |
| item_len | input | 32 | Length of the current item in bytes |
| item_ro | input | 1 | Current item is read-only |
| item_rdata | input | 8 | Item byte at the current offset |
| item_we | output | 1 | Item byte write strobe |
| item_wdata | output | 8 | Item byte write value |

## Verification
The bench targets the precedence of the flags. A descriptor with read, write and skip all set must read and leave the item untouched, and one with write and skip must write. A decoder with the wrong order would corrupt the item or drop data. Reads that run past the item's end must store zeros without flagging an error, and a design that stalled or stored stale bytes would show up there. A write one byte too long and a write to a read-only item must leave every item byte unchanged, because a design that checks only per beat would leave part of the data behind. The bench also retriggers and selects during a long read. A design that accepts those writes would process the second descriptor or lose the key. The high address half is checked to be forgotten after each operation, and the completion word is checked to arrive only after the last data byte.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    localparam int unsigned ADDR_W     = 64;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned DESC_WORDS = 4;

    // control word flag positions (fixed by the descriptor format)
    localparam int unsigned CTL_ERR  = 0;
    localparam int unsigned CTL_RD   = 1;
    localparam int unsigned CTL_SKIP = 2;
    localparam int unsigned CTL_SEL  = 3;
    localparam int unsigned CTL_WR   = 4;
    localparam int unsigned KEY_LSB  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEL,
        ST_DISP,
        ST_RD_PUT,
        ST_WR_GET,
        ST_WR_PUT,
        ST_WB
    } eng_state_e;

endpackage

// File: rtl/cfgdma_areg.sv
module cfgdma_areg
    import cfgdma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IDENT = 64'h5145_4D55_2043_4647
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_half_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    input  logic              reg_rhalf_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d  = addr_q;
        start_o = 1'b0;
        if (done_i) begin
            addr_d = '0;
        end else if (reg_wr_i && !busy_i) begin
            if (reg_half_i) begin
                addr_d[WORD_W-1:0] = reg_wdata_i;
                start_o            = 1'b1;
            end else begin
                addr_d[ADDR_W-1:WORD_W] = reg_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o      = addr_q;
    assign reg_rdata_o = reg_rhalf_i ? IDENT[WORD_W-1:0] : IDENT[ADDR_W-1:WORD_W];

    // R1: register is empty once an operation has finished
    p_addr_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> (addr_q == '0));

    // R11: register holds while the engine runs
    p_addr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(addr_q));

endmodule

// File: rtl/cfgdma_wrcheck.sv
module cfgdma_wrcheck #(
    parameter int unsigned LEN_W = 32
) (
    input  logic [LEN_W-1:0] off_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [LEN_W-1:0] item_len_i,
    input  logic             item_ro_i,
    output logic             ok_o
);

    localparam int unsigned SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] end_pos;

    always_comb begin
        end_pos = {1'b0, off_i} + {1'b0, req_len_i};
        ok_o    = !item_ro_i && (end_pos <= {1'b0, item_len_i});
    end

endmodule

// File: rtl/cfgdma_core.sv
module cfgdma_core
    import cfgdma_pkg::*;
#(
    parameter int unsigned KEY_W = 16,
    parameter int unsigned LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic              sel_wr_i,
    input  logic [KEY_W-1:0]  sel_key_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_byte_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [KEY_W-1:0]  key_o,
    output logic [LEN_W-1:0]  off_o,
    input  logic [LEN_W-1:0]  item_len_i,
    input  logic              item_ro_i,
    input  logic [BYTE_W-1:0] item_rdata_i,
    output logic              item_we_o,
    output logic [BYTE_W-1:0] item_wdata_o
);

    localparam int unsigned IDX_W  = $clog2(DESC_WORDS);
    localparam int unsigned PAD_W  = ADDR_W - IDX_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  widx;
        logic [KEY_W-1:0]  dkey;
        logic              fsel;
        logic              frd;
        logic              fwr;
        logic              fsk;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] taddr;
        logic [LEN_W-1:0]  rem;
        logic              err;
        logic [KEY_W-1:0]  key;
        logic [LEN_W-1:0]  off;
        logic [BYTE_W-1:0] dbyte;
    } core_s;

    core_s d, q;
    logic  wr_ok;
    logic  in_range;
    logic  last_beat;

    cfgdma_wrcheck #(.LEN_W(LEN_W)) u_wrcheck (
        .off_i      (q.off),
        .req_len_i  (q.len),
        .item_len_i (item_len_i),
        .item_ro_i  (item_ro_i),
        .ok_o       (wr_ok)
    );

    assign in_range  = (q.off < item_len_i);
    assign last_beat = (q.rem == LEN_W'(1));

    always_comb begin
        d            = q;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_byte_o   = 1'b0;
        mem_addr_o   = q.taddr;
        mem_wdata_o  = '0;
        item_we_o    = 1'b0;
        item_wdata_o = q.dbyte;
        done_o       = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (sel_wr_i) begin
                    d.key = sel_key_i;
                    d.off = '0;
                end
                if (start_i) begin
                    d.st   = ST_FETCH;
                    d.widx = '0;
                    d.err  = 1'b0;
                end
            end

            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr_i + {{PAD_W{1'b0}}, q.widx, 2'b00};
                if (mem_ack_i) begin
                    case (q.widx)
                        IDX_W'(0): begin
                            d.dkey = mem_rdata_i[KEY_LSB +: KEY_W];
                            d.fsel = mem_rdata_i[CTL_SEL];
                            d.frd  = mem_rdata_i[CTL_RD];
                            d.fwr  = mem_rdata_i[CTL_WR];
                            d.fsk  = mem_rdata_i[CTL_SKIP];
                        end
                        IDX_W'(1): d.len = mem_rdata_i[LEN_W-1:0];
                        IDX_W'(2): d.taddr[ADDR_W-1:WORD_W] = mem_rdata_i;
                        default:   d.taddr[WORD_W-1:0] = mem_rdata_i;
                    endcase
                    d.widx = q.widx + IDX_W'(1);
                    if (q.widx == LAST_IDX) begin
                        d.st = q.fsel ? ST_SEL : ST_DISP;
                    end
                end
            end

            ST_SEL: begin
                d.key = q.dkey;
                d.off = '0;
                d.st  = ST_DISP;
            end

            ST_DISP: begin
                d.rem = '0;
                d.st  = ST_WB;
                if (q.frd) begin
                    d.rem = q.len;
                    if (q.len != '0) d.st = ST_RD_PUT;
                end else if (q.fwr) begin
                    if (!wr_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.rem = q.len;
                        if (q.len != '0) d.st = ST_WR_GET;
                    end
                end else if (q.fsk) begin
                    d.off = q.off + q.len;
                end
            end

            ST_RD_PUT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_byte_o  = 1'b1;
                mem_wdata_o = {{(WORD_W-BYTE_W){1'b0}}, (in_range ? item_rdata_i : '0)};
                if (mem_ack_i) begin
                    d.off   = q.off + LEN_W'(1);
                    d.taddr = q.taddr + ADDR_W'(1);
                    d.rem   = q.rem - LEN_W'(1);
                    if (last_beat) d.st = ST_WB;
                end
            end

            ST_WR_GET: begin
                mem_req_o  = 1'b1;
                mem_byte_o = 1'b1;
                if (mem_ack_i) begin
                    d.dbyte = mem_rdata_i[BYTE_W-1:0];
                    d.st    = ST_WR_PUT;
                end
            end

            ST_WR_PUT: begin
                item_we_o = 1'b1;
                d.off     = q.off + LEN_W'(1);
                d.taddr   = q.taddr + ADDR_W'(1);
                d.rem     = q.rem - LEN_W'(1);
                d.st      = last_beat ? ST_WB : ST_WR_GET;
            end

            ST_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_addr_i;
                mem_wdata_o = {{(WORD_W-1){1'b0}}, q.err};
                if (mem_ack_i) begin
                    d.st   = ST_IDLE;
                    done_o = 1'b1;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign key_o  = q.key;
    assign off_o  = q.off;

    // R4: a pending request keeps its address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R6: a read completes without the error bit
    p_read_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WB && q.frd) |-> !q.err);

    // R8: no item byte is written by a rejected or lower-priority write
    p_item_write_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        item_we_o |-> (!q.err && q.fwr && !q.frd));

    // R10: completion word only after the last data beat
    p_wb_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !mem_byte_o) |-> (q.rem == '0));

    // R11: key changes only by selector port while idle or by descriptor select
    p_key_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.st != ST_SEL) |=> $stable(q.key));

    // R9: a skip moves no data
    p_skip_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DISP && q.fsk && !q.frd && !q.fwr) |=> (q.st == ST_WB));

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
#(
    parameter int unsigned KEY_W = 16,
    parameter int unsigned LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_half,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rhalf,
    output logic [31:0]       reg_rdata,
    input  logic              sel_wr,
    input  logic [KEY_W-1:0]  sel_key,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [63:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [KEY_W-1:0]  item_key,
    output logic [LEN_W-1:0]  item_off,
    input  logic [LEN_W-1:0]  item_len,
    input  logic              item_ro,
    input  logic [7:0]        item_rdata,
    output logic              item_we,
    output logic [7:0]        item_wdata
);

    logic              start;
    logic              done;
    logic [ADDR_W-1:0] desc_addr;

    cfgdma_areg u_areg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_half_i  (reg_half),
        .reg_wdata_i (reg_wdata),
        .reg_rhalf_i (reg_rhalf),
        .reg_rdata_o (reg_rdata),
        .busy_i      (busy),
        .done_i      (done),
        .start_o     (start),
        .addr_o      (desc_addr)
    );

    cfgdma_core #(.KEY_W(KEY_W), .LEN_W(LEN_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .desc_addr_i  (desc_addr),
        .sel_wr_i     (sel_wr),
        .sel_key_i    (sel_key),
        .busy_o       (busy),
        .done_o       (done),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_byte_o   (mem_byte),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata),
        .key_o        (item_key),
        .off_o        (item_off),
        .item_len_i   (item_len),
        .item_ro_i    (item_ro),
        .item_rdata_i (item_rdata),
        .item_we_o    (item_we),
        .item_wdata_o (item_wdata)
    );

endmodule

// File: tb/tb_cfgdma_engine.sv
module tb_cfgdma_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_half = 1'b0, reg_rhalf = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_key = '0;
    logic        busy;
    logic        mem_req, mem_we, mem_byte, mem_ack;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [15:0] item_key;
    logic [31:0] item_off, item_len;
    logic        item_ro, item_we;
    logic [7:0]  item_rdata, item_wdata;

    logic [7:0]  mem [0:255];
    logic [7:0]  wbuf [0:7];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_wa = '0, tb_wd = '0;
    logic        mon_clr = 1'b0;
    logic        hi_seen, wb_seen, late;
    logic [2:0]  nf;
    logic [7:0]  nbw;
    logic [63:0] flog [0:3];

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgdma_engine dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_half(reg_half), .reg_wdata(reg_wdata),
        .reg_rhalf(reg_rhalf), .reg_rdata(reg_rdata),
        .sel_wr(sel_wr), .sel_key(sel_key), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .item_key(item_key), .item_off(item_off), .item_len(item_len),
        .item_ro(item_ro), .item_rdata(item_rdata),
        .item_we(item_we), .item_wdata(item_wdata)
    );

    // memory model: zero-wait, only low 8 address bits decoded
    logic [7:0] a8;
    assign a8      = mem_addr[7:0];
    assign mem_ack = mem_req;
    always_comb begin
        if (mem_byte) mem_rdata = {24'h0, mem[a8]};
        else          mem_rdata = {mem[a8], mem[a8+8'd1], mem[a8+8'd2], mem[a8+8'd3]};
    end

    always @(posedge clk) begin
        if (tb_we) mem[tb_wa] <= tb_wd;
        if (mon_clr) begin
            hi_seen <= 1'b0; wb_seen <= 1'b0; late <= 1'b0; nf <= '0; nbw <= '0;
        end else if (mem_req && mem_ack) begin
            if (mem_addr[63:8] != '0) hi_seen <= 1'b1;
            if (!mem_we && !mem_byte && nf < 3'd4) begin
                flog[nf[1:0]] <= mem_addr;
                nf <= nf + 3'd1;
            end
            if (mem_we && mem_byte) begin
                mem[a8] <= mem_wdata[7:0];
                nbw <= nbw + 8'd1;
                if (wb_seen) late <= 1'b1;
            end
            if (mem_we && !mem_byte) begin
                mem[a8] <= mem_wdata[31:24];
                mem[a8+8'd1] <= mem_wdata[23:16];
                mem[a8+8'd2] <= mem_wdata[15:8];
                mem[a8+8'd3] <= mem_wdata[7:0];
                wb_seen <= 1'b1;
            end
        end
    end

    // item model: key 0x0005 read-only 8 bytes (A0+i), key 0x0021 writable 6 bytes
    assign item_len   = (item_key == 16'h0005) ? 32'd8 : (item_key == 16'h0021) ? 32'd6 : 32'd0;
    assign item_ro    = (item_key != 16'h0021);
    assign item_rdata = (item_key == 16'h0021) ? wbuf[item_off[2:0]] : (8'hA0 + item_off[7:0]);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) wbuf[i] <= 8'h00;
        end else if (item_we) begin
            wbuf[item_off[2:0]] <= item_wdata;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] a, input logic [7:0] v);
        tb_we = 1'b1; tb_wa = a; tb_wd = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_word(input logic [7:0] a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) put_byte(a + 8'(i), w[31-8*i -: 8]);
    endtask

    task automatic put_desc(input logic [7:0] a, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [31:0] tgt);
        put_word(a, ctl);
        put_word(a + 8'd4, len);
        put_word(a + 8'd8, 32'h0);
        put_word(a + 8'd12, tgt);
    endtask

    function automatic logic [31:0] get_word(input logic [7:0] a);
        return {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic go(input logic use_hi, input logic [31:0] hi, input logic [31:0] lo);
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        if (use_hi) begin
            reg_wr = 1'b1; reg_half = 1'b0; reg_wdata = hi; @(negedge clk);
        end
        reg_wr = 1'b1; reg_half = 1'b1; reg_wdata = lo; @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R12 key after reset", 64'(item_key), 64'd0);
        chk("R12 offset after reset", 64'(item_off), 64'd0);
        reg_rhalf = 1'b0; #1;
        chk("R3 ident upper", 64'(reg_rdata), 64'h51454D55);
        reg_rhalf = 1'b1; #1;
        chk("R3 ident lower", 64'(reg_rdata), 64'h20434647);
    endtask

    task automatic t_read_hi();
        put_desc(8'h40, 32'h0005_000A, 32'd6, 32'h80);
        go(1'b1, 32'h1, 32'h40);
        chk("R2 upper half used", 64'(hi_seen), 64'd1);
        for (int i = 0; i < 4; i++)
            chk("R4 fetch address", flog[i], 64'h1_0000_0040 + 64'(4*i));
        for (int i = 0; i < 6; i++)
            chk("R6 read byte", 64'(mem[8'h80 + 8'(i)]), 64'(8'hA0 + 8'(i)));
        chk("R10 success word", 64'(get_word(8'h40)), 64'h0);
        chk("R5 key selected", 64'(item_key), 64'h5);
        chk("R6 offset advanced", 64'(item_off), 64'd6);
        chk("R10 no byte after writeback", 64'(late), 64'd0);
    endtask

    task automatic t_read_past();
        for (int i = 0; i < 4; i++) put_byte(8'h90 + 8'(i), 8'hFF);
        put_desc(8'h40, 32'h0000_0002, 32'd4, 32'h90);
        go(1'b0, 32'h0, 32'h40);
        chk("R1 upper half cleared", 64'(hi_seen), 64'd0);
        chk("R6 past-end byte 0", 64'(get_word(8'h90)), 64'hA6A70000);
        chk("R6 past-end no error", 64'(get_word(8'h40)), 64'h0);
        chk("R6 offset 10", 64'(item_off), 64'd10);
    endtask

    task automatic t_write();
        put_byte(8'hA0, 8'h11); put_byte(8'hA1, 8'h22); put_byte(8'hA2, 8'h33);
        put_desc(8'h40, 32'h0021_0018, 32'd3, 32'hA0);
        go(1'b0, 32'h0, 32'h40);
        chk("R7 item bytes", {40'h0, wbuf[0], wbuf[1], wbuf[2]}, 64'h112233);
        chk("R7 success word", 64'(get_word(8'h40)), 64'h0);
        chk("R7 offset", 64'(item_off), 64'd3);
        chk("R5 key 0x21", 64'(item_key), 64'h21);
    endtask

    task automatic t_precedence();
        put_desc(8'h40, 32'h0021_001E, 32'd3, 32'hB0);
        go(1'b0, 32'h0, 32'h40);
        chk("R6 read wins: data", {40'h0, mem[8'hB0], mem[8'hB1], mem[8'hB2]}, 64'h112233);
        chk("R6 read wins: item kept", {40'h0, wbuf[0], wbuf[1], wbuf[2]}, 64'h112233);
        chk("R6 read wins: offset", 64'(item_off), 64'd3);
        put_byte(8'hA4, 8'h55); put_byte(8'hA5, 8'h66);
        put_desc(8'h40, 32'h0021_001C, 32'd2, 32'hA4);
        go(1'b0, 32'h0, 32'h40);
        chk("R7 write beats skip", {40'h0, wbuf[0], wbuf[1], wbuf[2]}, 64'h556633);
        chk("R7 write offset", 64'(item_off), 64'd2);
    endtask

    task automatic t_write_err();
        put_desc(8'h40, 32'h0021_0018, 32'd7, 32'hA0);
        go(1'b0, 32'h0, 32'h40);
        chk("R8 overlong error word", 64'(get_word(8'h40)), 64'h1);
        chk("R8 item untouched", {40'h0, wbuf[0], wbuf[1], wbuf[2]}, 64'h556633);
        chk("R8 offset kept", 64'(item_off), 64'd0);
        put_desc(8'h40, 32'h0005_0018, 32'd1, 32'hA0);
        go(1'b0, 32'h0, 32'h40);
        chk("R8 read-only error word", 64'(get_word(8'h40)), 64'h1);
        chk("R8 read-only offset", 64'(item_off), 64'd0);
    endtask

    task automatic t_skip();
        put_byte(8'hC0, 8'hEE);
        put_desc(8'h40, 32'h0005_000C, 32'd3, 32'hC0);
        go(1'b0, 32'h0, 32'h40);
        chk("R9 offset advanced", 64'(item_off), 64'd3);
        chk("R9 no data bytes", 64'(nbw), 64'd0);
        chk("R9 target untouched", 64'(mem[8'hC0]), 64'hEE);
        chk("R9 success word", 64'(get_word(8'h40)), 64'h0);
        put_desc(8'h40, 32'h0000_0002, 32'd1, 32'hC1);
        go(1'b0, 32'h0, 32'h40);
        chk("R9 read after skip", 64'(mem[8'hC1]), 64'hA3);
    endtask

    task automatic t_sel_port();
        @(negedge clk);
        sel_wr = 1'b1; sel_key = 16'h0021; @(negedge clk);
        sel_wr = 1'b0;
        chk("R12 selector key", 64'(item_key), 64'h21);
        chk("R12 selector offset", 64'(item_off), 64'd0);
    endtask

    task automatic t_busy();
        put_desc(8'h40, 32'h0005_000A, 32'd20, 32'hD0);
        put_desc(8'h60, 32'h0000_0004, 32'd5, 32'h0);
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        reg_wr = 1'b1; reg_half = 1'b1; reg_wdata = 32'h40; @(negedge clk);
        reg_wdata = 32'h60; sel_wr = 1'b1; sel_key = 16'h0021; @(negedge clk);
        reg_wr = 1'b0; sel_wr = 1'b0;
        wait_idle();
        chk("R11 key kept", 64'(item_key), 64'h5);
        chk("R11 offset from first op", 64'(item_off), 64'd20);
        chk("R11 second descriptor untouched", 64'(get_word(8'h60)), 64'h4);
        chk("R6 in-range byte", 64'(mem[8'hD7]), 64'hA7);
        chk("R6 out-of-range byte", 64'(mem[8'hD8]), 64'h00);
        repeat (5) @(negedge clk);
        chk("R11 no second operation", 64'(busy), 64'd0);
        chk("R10 no byte after writeback", 64'(late), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_hi();
        t_read_past();
        t_write();
        t_precedence();
        t_write_err();
        t_skip();
        t_sel_port();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule